// File: doc/BRIEF.md
# Loop Up/Down Code Detector and Generator

This block watches a bit-serial T1 receive stream for the two in-band loopback commands: the activate code, a five-bit cell `00001` sent over and over, and the deactivate code, a three-bit cell `001` sent over and over. Each counted bit is compared with the counted bit one code period earlier, five bits back for activate and three bits back for deactivate. Because of this, the detector does not need to know where a cell begins. Mismatches and ones are counted over a fixed window of counted bits. A window counts as a match when its mismatch count is within a tolerance and its ones count fits the density that the code implies. The density test is what stops a constant stream from being taken for either code.

A detection flag changes state only after a run of consecutive windows that disagree with its current state, with the same run length for setting and for clearing. A one-cycle interrupt pulse marks each time a flag sets. When framed operation is selected, bits flagged as sitting in the framing position are left out of both comparison and window counting.

On the transmit side, the block forwards the payload unchanged unless a send command is active. While a command is active, it puts the chosen code in place of the payload bits, restarting the cell from its first bit whenever the command changes. Bits flagged as framing positions always pass through from the input.

Top module: `loopCodeUnit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `loopUpSeen`, `loopDownSeen`, `loopUpIrq`, `loopDownIrq`, `txOut` and `txOutValid` are all 0.
- R2: Once `CONFIRM_WINDOWS` consecutive windows of clean activate code (repeating 00001, any starting phase) have been received, `loopUpSeen` is 1, and it is still 0 after the first window.
- R3: Once `CONFIRM_WINDOWS` consecutive windows of clean deactivate code (repeating 001, any phase) have been received, `loopDownSeen` is 1. The activate code never sets `loopDownSeen`, and the deactivate code never sets `loopUpSeen`.
- R4: A window in which one payload bit is inverted, which gives two period mismatches, still counts as a match when `MAX_ERRS` is 2 or more.
- R5: A window whose period mismatch count is above `MAX_ERRS` does not count as a match, so a stream with that many errors in every window never sets a flag.
- R6: A bit with `rxValid` low is ignored. With `rxFramed` high, a bit with `rxFbit` high is excluded from comparison and from the window count. With `rxFramed` low, such bits are treated as payload.
- R7: All-zero windows and all-one windows match neither code. The ones count must lie between floor(W/P)-MAX_ERRS and ceil(W/P)+MAX_ERRS, where W is the window length and P the code period.
- R8: A set flag stays set after `CONFIRM_WINDOWS`-1 non-matching windows and clears once `CONFIRM_WINDOWS` consecutive non-matching windows have been received.
- R9: `loopUpIrq` and `loopDownIrq` each pulse high for exactly one cycle, in the cycle their flag goes from 0 to 1, and never when it clears.
- R10: With neither send command active, `txOut` equals the `txIn` of the previous cycle in which `txValid` was high, and `txOutValid` is `txValid` delayed by one cycle.
- R11: With `txSendUp` high, the non-framing bits on `txOut` follow 0,0,0,0,1 repeating, starting with the first 0 at the first valid bit after the command changes.
- R12: With `txSendDown` high and `txSendUp` low, the non-framing bits on `txOut` follow 0,0,1 repeating from the first 0. When both commands are high, the activate code is sent.
- R13: A valid transmit bit with `txFbitPos` high is forwarded from `txIn` to `txOut` whatever command is active, and it does not advance the code cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Received data bit |
| rxValid | input | 1 | Received bit strobe |
| rxFbit | input | 1 | Received bit is in the framing position |
| rxFramed | input | 1 | 1: leave framing-position bits out of detection |
| txIn | input | 1 | Transmit payload or framing bit |
| txValid | input | 1 | Transmit bit strobe |
| txFbitPos | input | 1 | Transmit bit is in the framing position |
| txSendUp | input | 1 | Send the activate code |
| txSendDown | input | 1 | Send the deactivate code |
| txOut | output | 1 | Transmit bit after code insertion |
| txOutValid | output | 1 | Strobe for `txOut` |
| loopUpSeen | output | 1 | Activate code detected |
| loopDownSeen | output | 1 | Deactivate code detected |
| loopUpIrq | output | 1 | One-cycle pulse when `loopUpSeen` sets |
| loopDownIrq | output | 1 | One-cycle pulse when `loopDownSeen` sets |

## Verification
The bench builds the unit with a 40-bit window, a tolerance of 2 mismatches and a confirmation run of 2 windows. At these values one window of code plus a single transition mismatch already counts as a match, and the exact window in which a flag sets or clears follows from bit counts. Every starting phase of both codes fits into a few hundred cycles. One inverted bit gives exactly two mismatches, which stays within the tolerance, and two inverted bits go past it. Both density bounds (6 to 10 ones for activate, 11 to 16 for deactivate) are narrow enough that all-zero, all-one and stuffed streams fall outside them.

// File: rtl/lcPkg.sv
package lcPkg;

  localparam int UP_LEN   = 5;
  localparam int DOWN_LEN = 3;
  localparam int NUM_CODES = 2;

  typedef enum logic [1:0] {
    TX_PASS = 2'd0,
    TX_UP   = 2'd1,
    TX_DOWN = 2'd2
  } txMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    countBit;
    logic    lastBit;
    logic    txRestart;
    logic    txAdvance;
    txMode_e txMode;
  } lcCtl_t;

  // window verdict from datapath to control; match[0] activate, match[1] deactivate
  typedef struct packed {
    logic                 valid;
    logic [NUM_CODES-1:0] match;
  } lcVerdict_t;

endpackage

// File: rtl/lcCodeTracker.sv
module lcCodeTracker #(
  parameter int PERIOD      = 5,
  parameter int WINDOW_BITS = 1000,
  parameter int MAX_ERRS    = 10,
  parameter int CW          = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          countBit,
  input  logic          lastBit,
  input  logic          mismatch,
  input  logic [CW-1:0] onesNext,
  output logic          matchQ
);

  localparam int ONES_FLOOR = WINDOW_BITS / PERIOD;
  localparam int ONES_CEIL  = (WINDOW_BITS + PERIOD - 1) / PERIOD;
  localparam int ONES_LO    = (ONES_FLOOR > MAX_ERRS) ? ONES_FLOOR - MAX_ERRS : 0;
  localparam int ONES_HI    = ONES_CEIL + MAX_ERRS;

  logic [CW-1:0] errCnt;
  logic [CW-1:0] errNext;
  logic          densityOk;
  logic          errorsOk;

  assign errNext   = errCnt + CW'(mismatch);
  assign densityOk = (int'(onesNext) >= ONES_LO) && (int'(onesNext) <= ONES_HI);
  assign errorsOk  = int'(errNext) <= MAX_ERRS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt <= '0;
      matchQ <= 1'b0;
    end else if (countBit) begin
      if (lastBit) begin
        errCnt <= '0;
        matchQ <= errorsOk && densityOk;
      end else begin
        errCnt <= errNext;
      end
    end
  end

endmodule

// File: rtl/lcDatapath.sv
module lcDatapath import lcPkg::*; #(
  parameter int WINDOW_BITS = 1000,
  parameter int MAX_ERRS    = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  lcCtl_t     ctl,
  input  logic       rxBit,
  input  logic       txIn,
  input  logic       txValid,
  input  logic       txFbitPos,
  output lcVerdict_t verdict,
  output logic       txOut,
  output logic       txOutValid
);

  localparam int CW = $clog2(WINDOW_BITS + 1);
  localparam int FW = $clog2(UP_LEN + 1);
  localparam int PW = $clog2(UP_LEN);

  // ---------------- receive side ----------------
  logic [UP_LEN-1:0]    hist;      // hist[0] newest counted bit
  logic [FW-1:0]        histFill;
  logic [CW-1:0]        onesCnt;
  logic [CW-1:0]        onesNext;
  logic [NUM_CODES-1:0] mis;
  logic [NUM_CODES-1:0] matchQ;
  logic                 verdictValid;

  assign onesNext = onesCnt + CW'(rxBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist     <= '0;
      histFill <= '0;
      onesCnt  <= '0;
    end else if (ctl.countBit) begin
      hist <= {hist[UP_LEN-2:0], rxBit};
      if (histFill != FW'(UP_LEN)) histFill <= histFill + 1'b1;
      onesCnt <= ctl.lastBit ? '0 : onesNext;
    end
  end

  for (genvar g = 0; g < NUM_CODES; g++) begin : gCode
    localparam int PERIOD = (g == 0) ? UP_LEN : DOWN_LEN;
    assign mis[g] = (histFill >= FW'(PERIOD)) && (rxBit != hist[PERIOD-1]);
    lcCodeTracker #(
      .PERIOD     (PERIOD),
      .WINDOW_BITS(WINDOW_BITS),
      .MAX_ERRS   (MAX_ERRS),
      .CW         (CW)
    ) tracker_i (
      .clk     (clk),
      .rstN    (rstN),
      .countBit(ctl.countBit),
      .lastBit (ctl.lastBit),
      .mismatch(mis[g]),
      .onesNext(onesNext),
      .matchQ  (matchQ[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) verdictValid <= 1'b0;
    else       verdictValid <= ctl.countBit && ctl.lastBit;
  end

  assign verdict.valid = verdictValid;
  assign verdict.match = matchQ;

  // ---------------- transmit side ----------------
  logic [PW-1:0] phase;
  logic [PW-1:0] idx;
  logic [PW-1:0] lastIdx;
  logic          codeBit;
  logic          useCode;

  assign idx     = ctl.txRestart ? '0 : phase;
  assign lastIdx = (ctl.txMode == TX_UP) ? PW'(UP_LEN - 1) : PW'(DOWN_LEN - 1);
  assign codeBit = (idx == lastIdx);
  assign useCode = (ctl.txMode != TX_PASS) && !txFbitPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= '0;
      txOut      <= 1'b0;
      txOutValid <= 1'b0;
    end else begin
      txOutValid <= txValid;
      if (txValid) txOut <= useCode ? codeBit : txIn;
      if (ctl.txAdvance)      phase <= (idx == lastIdx) ? '0 : idx + 1'b1;
      else if (ctl.txRestart) phase <= '0;
    end
  end

endmodule

// File: rtl/lcControl.sv
module lcControl import lcPkg::*; #(
  parameter int WINDOW_BITS     = 1000,
  parameter int CONFIRM_WINDOWS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxValid,
  input  logic                 rxFbit,
  input  logic                 rxFramed,
  input  logic                 txValid,
  input  logic                 txFbitPos,
  input  logic                 txSendUp,
  input  logic                 txSendDown,
  input  lcVerdict_t           verdict,
  output lcCtl_t               ctl,
  output logic [NUM_CODES-1:0] seen,
  output logic [NUM_CODES-1:0] irq
);

  localparam int WW = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1;
  localparam int RW = $clog2(CONFIRM_WINDOWS + 1);

  // ---------------- window framing ----------------
  logic [WW-1:0] winCnt;
  logic          countBit;
  logic          lastBit;

  assign countBit = rxValid && !(rxFramed && rxFbit);
  assign lastBit  = (winCnt == WW'(WINDOW_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN)         winCnt <= '0;
    else if (countBit) winCnt <= lastBit ? '0 : winCnt + 1'b1;
  end

  // ---------------- transmit command ----------------
  txMode_e mode;
  txMode_e prevMode;

  always_comb begin
    if (txSendUp)        mode = TX_UP;
    else if (txSendDown) mode = TX_DOWN;
    else                 mode = TX_PASS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevMode <= TX_PASS;
    else       prevMode <= mode;
  end

  assign ctl.countBit  = countBit;
  assign ctl.lastBit   = lastBit;
  assign ctl.txMode    = mode;
  assign ctl.txRestart = (mode != prevMode);
  assign ctl.txAdvance = txValid && !txFbitPos && (mode != TX_PASS);

  // ---------------- confirmation per code ----------------
  for (genvar g = 0; g < NUM_CODES; g++) begin : gConfirm
    logic [RW-1:0] run;
    logic          flag;
    logic          pulse;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        run   <= '0;
        flag  <= 1'b0;
        pulse <= 1'b0;
      end else begin
        pulse <= 1'b0;
        if (verdict.valid) begin
          if (verdict.match[g] == flag) begin
            run <= '0;
          end else if (run == RW'(CONFIRM_WINDOWS - 1)) begin
            run   <= '0;
            flag  <= ~flag;
            pulse <= ~flag;
          end else begin
            run <= run + 1'b1;
          end
        end
      end
    end

    assign seen[g] = flag;
    assign irq[g]  = pulse;
  end

endmodule

// File: rtl/loopCodeUnit.sv
module loopCodeUnit import lcPkg::*; #(
  parameter int WINDOW_BITS     = 1000,
  parameter int MAX_ERRS        = 10,
  parameter int CONFIRM_WINDOWS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxBit,
  input  logic rxValid,
  input  logic rxFbit,
  input  logic rxFramed,
  input  logic txIn,
  input  logic txValid,
  input  logic txFbitPos,
  input  logic txSendUp,
  input  logic txSendDown,
  output logic txOut,
  output logic txOutValid,
  output logic loopUpSeen,
  output logic loopDownSeen,
  output logic loopUpIrq,
  output logic loopDownIrq
);

  lcCtl_t               ctlStrobes;
  lcVerdict_t           dpVerdict;
  logic [NUM_CODES-1:0] seen;
  logic [NUM_CODES-1:0] irq;

  lcControl #(
    .WINDOW_BITS    (WINDOW_BITS),
    .CONFIRM_WINDOWS(CONFIRM_WINDOWS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .rxValid   (rxValid),
    .rxFbit    (rxFbit),
    .rxFramed  (rxFramed),
    .txValid   (txValid),
    .txFbitPos (txFbitPos),
    .txSendUp  (txSendUp),
    .txSendDown(txSendDown),
    .verdict   (dpVerdict),
    .ctl       (ctlStrobes),
    .seen      (seen),
    .irq       (irq)
  );

  lcDatapath #(
    .WINDOW_BITS(WINDOW_BITS),
    .MAX_ERRS   (MAX_ERRS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlStrobes),
    .rxBit     (rxBit),
    .txIn      (txIn),
    .txValid   (txValid),
    .txFbitPos (txFbitPos),
    .verdict   (dpVerdict),
    .txOut     (txOut),
    .txOutValid(txOutValid)
  );

  assign loopUpSeen   = seen[0];
  assign loopDownSeen = seen[1];
  assign loopUpIrq    = irq[0];
  assign loopDownIrq  = irq[1];

endmodule

// File: rtl/lcChecker.sv
module lcChecker (
  input logic clk,
  input logic rstN,
  input logic verdictValid,
  input logic txIn,
  input logic txValid,
  input logic txFbitPos,
  input logic txSendUp,
  input logic txSendDown,
  input logic txOut,
  input logic txOutValid,
  input logic loopUpSeen,
  input logic loopDownSeen,
  input logic loopUpIrq,
  input logic loopDownIrq
);

  assert_irq_up_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    loopUpIrq |-> (loopUpSeen && !$past(loopUpSeen)));

  assert_irq_down_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    loopDownIrq |-> (loopDownSeen && !$past(loopDownSeen)));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loopUpIrq || loopDownIrq) |=> (!loopUpIrq && !loopDownIrq));

  assert_flag_only_on_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    !verdictValid |=> ($stable(loopUpSeen) && $stable(loopDownSeen)));

  assert_tx_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> txOutValid);

  assert_tx_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |=> !txOutValid);

  assert_tx_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txSendUp && !txSendDown) |=> (txOut == $past(txIn)));

  assert_tx_framing_R13: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txFbitPos) |=> (txOut == $past(txIn)));

endmodule

bind loopCodeUnit lcChecker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .verdictValid(dpVerdict.valid),
  .txIn        (txIn),
  .txValid     (txValid),
  .txFbitPos   (txFbitPos),
  .txSendUp    (txSendUp),
  .txSendDown  (txSendDown),
  .txOut       (txOut),
  .txOutValid  (txOutValid),
  .loopUpSeen  (loopUpSeen),
  .loopDownSeen(loopDownSeen),
  .loopUpIrq   (loopUpIrq),
  .loopDownIrq (loopDownIrq)
);

// File: tb/loopCodeUnit_tb_top.sv
`timescale 1ns/1ps
module loopCodeUnit_tb_top;

  localparam int W    = 40;
  localparam int E    = 2;
  localparam int CONF = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxBit = 1'b0, rxValid = 1'b0, rxFbit = 1'b0, rxFramed = 1'b0;
  logic txIn = 1'b0, txValid = 1'b0, txFbitPos = 1'b0, txSendUp = 1'b0, txSendDown = 1'b0;
  logic txOut, txOutValid, loopUpSeen, loopDownSeen, loopUpIrq, loopDownIrq;

  int checks = 0;
  int errors = 0;
  int codePos = 0;
  int rxCount = 0;
  int upIrqCnt = 0;
  int downIrqCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loopCodeUnit #(
    .WINDOW_BITS(W), .MAX_ERRS(E), .CONFIRM_WINDOWS(CONF)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .rxBit(rxBit), .rxValid(rxValid), .rxFbit(rxFbit), .rxFramed(rxFramed),
    .txIn(txIn), .txValid(txValid), .txFbitPos(txFbitPos),
    .txSendUp(txSendUp), .txSendDown(txSendDown),
    .txOut(txOut), .txOutValid(txOutValid),
    .loopUpSeen(loopUpSeen), .loopDownSeen(loopDownSeen),
    .loopUpIrq(loopUpIrq), .loopDownIrq(loopDownIrq)
  );

  always @(negedge clk) begin
    if (rstN && loopUpIrq)   upIrqCnt++;
    if (rstN && loopDownIrq) downIrqCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // period 0: zeros, 1: ones, otherwise the code with a 1 at the last cell position
  task automatic rxBits(input int period, input int n, input int flipA, input int flipB,
                        input bit withF, input bit idleGaps);
    for (int i = 0; i < n; i++) begin
      bit b;
      if (period == 0)      b = 1'b0;
      else if (period == 1) b = 1'b1;
      else                  b = ((codePos % period) == period - 1);
      if (i == flipA || i == flipB) b = ~b;
      codePos++;
      if (withF && (i % 6 == 3)) begin
        @(negedge clk); rxBit = 1'b1; rxFbit = 1'b1; rxValid = 1'b1;
        if (!rxFramed) rxCount++;
      end
      if (idleGaps && (i % 5 == 2)) begin
        @(negedge clk); rxBit = 1'b1; rxFbit = 1'b0; rxValid = 1'b0;
      end
      @(negedge clk); rxBit = b; rxFbit = 1'b0; rxValid = 1'b1;
      rxCount++;
    end
    @(negedge clk); rxValid = 1'b0; rxFbit = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic padWindow();
    int n;
    n = (W - (rxCount % W)) % W;
    if (n > 0) rxBits(0, n, -1, -1, 1'b0, 1'b0);
  endtask

  // transmit stepping with an arithmetic reference of the code cell
  int txIdx = 0;
  int prevCmd = 0;
  bit havePrev = 1'b0;
  int expOut = 0;
  int expValid = 0;

  task automatic txStep(input bit din, input bit vld, input bit fb, input bit up,
                        input bit dn, input string req);
    int cmd;
    int last;
    @(negedge clk);
    if (havePrev) begin
      check({req, " txOutValid"}, int'(txOutValid), expValid);
      if (expValid != 0) check({req, " txOut"}, int'(txOut), expOut);
    end
    txIn = din; txValid = vld; txFbitPos = fb; txSendUp = up; txSendDown = dn;
    cmd  = up ? 1 : (dn ? 2 : 0);
    if (cmd != prevCmd) txIdx = 0;
    prevCmd = cmd;
    last = (cmd == 1) ? 4 : 2;
    expValid = vld;
    if (vld) begin
      if (cmd == 0 || fb) expOut = din;
      else begin
        expOut = (txIdx == last) ? 1 : 0;
        txIdx = (txIdx == last) ? 0 : txIdx + 1;
      end
    end
    havePrev = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int irqBefore;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 up flag", int'(loopUpSeen), 0);
    check("R1 down flag", int'(loopDownSeen), 0);
    check("R1 irq", int'(loopUpIrq | loopDownIrq), 0);
    check("R1 tx", int'(txOut | txOutValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(loopUpSeen | loopDownSeen | txOutValid), 0);

    // R7: constant streams match neither code
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    check("R7 zeros up", int'(loopUpSeen), 0);
    check("R7 zeros down", int'(loopDownSeen), 0);
    rxBits(1, W, -1, -1, 1'b0, 1'b0);
    rxBits(1, W, -1, -1, 1'b0, 1'b0);
    rxBits(1, W, -1, -1, 1'b0, 1'b0);
    check("R7 ones up", int'(loopUpSeen), 0);
    check("R7 ones down", int'(loopDownSeen), 0);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);

    // R2, R8, R9: activate code at every phase
    for (int p = 0; p < 5; p++) begin
      irqBefore = upIrqCnt;
      codePos = p;
      rxBits(5, W, -1, -1, 1'b0, 1'b0);
      check("R8 up not after one window", int'(loopUpSeen), 0);
      rxBits(5, W, -1, -1, 1'b0, 1'b0);
      check("R2 up set", int'(loopUpSeen), 1);
      check("R3 up code leaves down clear", int'(loopDownSeen), 0);
      check("R9 one up pulse", upIrqCnt - irqBefore, 1);
      rxBits(0, W, -1, -1, 1'b0, 1'b0);
      check("R8 up held", int'(loopUpSeen), 1);
      rxBits(0, W, -1, -1, 1'b0, 1'b0);
      check("R8 up cleared", int'(loopUpSeen), 0);
      check("R9 no pulse on clear", upIrqCnt - irqBefore, 1);
    end

    // R3, R8, R9: deactivate code at every phase
    for (int p = 0; p < 3; p++) begin
      irqBefore = downIrqCnt;
      codePos = p;
      rxBits(3, W, -1, -1, 1'b0, 1'b0);
      check("R8 down not after one window", int'(loopDownSeen), 0);
      rxBits(3, W, -1, -1, 1'b0, 1'b0);
      check("R3 down set", int'(loopDownSeen), 1);
      check("R3 down code leaves up clear", int'(loopUpSeen), 0);
      check("R9 one down pulse", downIrqCnt - irqBefore, 1);
      rxBits(0, W, -1, -1, 1'b0, 1'b0);
      check("R8 down held", int'(loopDownSeen), 1);
      rxBits(0, W, -1, -1, 1'b0, 1'b0);
      check("R8 down cleared", int'(loopDownSeen), 0);
    end

    // R4: one inverted bit per window is tolerated
    codePos = 0;
    rxBits(5, W, -1, -1, 1'b0, 1'b0);
    rxBits(5, W, 20, -1, 1'b0, 1'b0);
    check("R4 up with single errors", int'(loopUpSeen), 1);
    rxBits(5, W, 17, -1, 1'b0, 1'b0);
    rxBits(5, W, 31, -1, 1'b0, 1'b0);
    check("R4 up kept with single errors", int'(loopUpSeen), 1);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    codePos = 1;
    rxBits(3, W, -1, -1, 1'b0, 1'b0);
    rxBits(3, W, 20, -1, 1'b0, 1'b0);
    check("R4 down with single errors", int'(loopDownSeen), 1);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);

    // R5: two inverted bits per window exceed the tolerance
    codePos = 0;
    for (int k = 0; k < 4; k++) begin
      rxBits(5, W, 10, 25, 1'b0, 1'b0);
      check("R5 up rejected", int'(loopUpSeen), 0);
    end
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    codePos = 0;
    for (int k = 0; k < 4; k++) begin
      rxBits(3, W, 10, 25, 1'b0, 1'b0);
      check("R5 down rejected", int'(loopDownSeen), 0);
    end
    rxBits(0, W, -1, -1, 1'b0, 1'b0);

    // R6: framed mode skips framing bits and idle cycles
    rxFramed = 1'b1;
    codePos = 2;
    rxBits(5, W, -1, -1, 1'b1, 1'b1);
    rxBits(5, W, -1, -1, 1'b1, 1'b1);
    check("R6 framed up set", int'(loopUpSeen), 1);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);
    check("R6 framed up cleared", int'(loopUpSeen), 0);
    // unframed: the same stuffed bits count as payload and spoil the code
    rxFramed = 1'b0;
    codePos = 0;
    irqBefore = upIrqCnt;
    for (int k = 0; k < 4; k++) rxBits(5, W, -1, -1, 1'b1, 1'b0);
    padWindow();
    check("R6 unframed stuffed not detected", int'(loopUpSeen), 0);
    check("R6 unframed no pulse", upIrqCnt - irqBefore, 0);
    rxBits(0, W, -1, -1, 1'b0, 1'b0);

    // R10: pass-through with a gap
    for (int i = 0; i < 24; i++)
      txStep(((i * 7) % 3) == 1, (i % 9) != 4, (i % 6) == 5, 1'b0, 1'b0, "R10");
    // R11 and R13: activate code with framing positions
    for (int i = 0; i < 30; i++)
      txStep(((i * 5) % 4) == 0, (i % 11) != 7, (i % 6) == 2, 1'b1, 1'b0, "R11/R13");
    // R12: deactivate code, then both commands
    for (int i = 0; i < 24; i++)
      txStep(((i * 3) % 5) != 0, 1'b1, (i % 7) == 3, 1'b0, 1'b1, "R12");
    for (int i = 0; i < 20; i++)
      txStep(1'b1, 1'b1, (i % 8) == 6, 1'b1, 1'b1, "R12 both");
    for (int i = 0; i < 6; i++)
      txStep(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 back");
    txStep(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 end");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule